// File: doc/BRIEF.md
# Single-Cycle Accumulator Core

This block is a small processor core built around one 8-bit accumulator. A 16-bit instruction word is fetched from the instruction port at the address held in the program counter. The word is decoded and fully executed within the same clock: the accumulator, the program counter and any data-memory write all take effect at the next rising edge. The upper byte of each word selects the operation. The lower byte is an operand that serves as an immediate value, a data address or a branch target, depending on the operation.

Instruction fetch and data access use separate ports. Both memories sit outside the core and answer reads combinationally. Data writes take place on the clock edge while the write strobe is high. The program counter counts in bytes and steps by 2 per instruction. A branch loads the operand into it when an unconditional-jump control is set or when a branch-if-nonzero control meets a nonzero accumulator. All arithmetic wraps modulo 256.

Top module: `acc_core`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the program counter and the accumulator become 0 at the next rising edge.
- R2: The instruction word is 16 bits, with the opcode in bits [15:8] and the operand in bits [7:0]. Every instruction that does not branch advances the program counter by 2, modulo 256, so 254 is followed by 0.
- R3: Opcode 0x00 (clear) sets the accumulator to 0.
- R4: Opcode 0x01 (add immediate) sets the accumulator to accumulator + operand, modulo 256.
- R5: Opcode 0x02 (add from memory) places the operand on the data address and sets the accumulator to accumulator + data read value, modulo 256.
- R6: Opcode 0x03 (store) raises the data write strobe for that cycle, with the operand on the data address and the accumulator on the write data. The accumulator stays unchanged.
- R7: Opcode 0x04 (branch if nonzero) loads the operand into the program counter when the accumulator is nonzero. When the accumulator is zero it advances the program counter by 2. The accumulator stays unchanged in both cases.
- R8: Opcode 0x05 (link) sets the accumulator to the program counter + 2, modulo 256.
- R9: Any other opcode is a no-op. The program counter advances by 2, the accumulator is unchanged and no data write takes place.
- R10: The data write strobe is high only while a store instruction is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction fetch byte address (program counter) |
| imem_rdata | input | 16 | Instruction word at imem_addr |
| dmem_addr | output | 8 | Data memory address (operand field) |
| dmem_wdata | output | 8 | Data to write (accumulator) |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 8 | Data memory read value at dmem_addr |
| acc_value | output | 8 | Current accumulator contents |

## Verification
The assertions assume that the instruction and data ports return stable, defined values within the same cycle that an address is presented. They also assume that branch targets are even, so that fetches stay word-aligned. The stimulus meets these conditions with bench arrays that read combinationally and write only on the clock edge, and with a program whose every target is even. The program drives the counter through 254 into 0, makes the additions wrap, exercises both branch outcomes and includes an undefined opcode. A second reset is applied partway through the run. Each cycle, a behavioural model checks the fetch address, the accumulator and the write port.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  typedef enum logic [2:0] {
    ALU_NONE   = 3'd0,
    ALU_PASS_X = 3'd1,
    ALU_SUB    = 3'd2,
    ALU_PASS_Y = 3'd3,
    ALU_ZERO   = 3'd4,
    ALU_ADD    = 3'd5
  } alu_op_e;

  typedef enum logic {
    ASRC_ALU  = 1'b0,
    ASRC_LINK = 1'b1
  } acc_src_e;

  typedef enum logic {
    YSRC_IMM = 1'b0,
    YSRC_MEM = 1'b1
  } y_src_e;

  typedef struct packed {
    logic     acc_we;
    logic     mem_we;
    acc_src_e acc_src;
    y_src_e   y_src;
    alu_op_e  alu_op;
    logic     br_nz;
    logic     jump;
  } ctrl_t;

  localparam int OP_CLEAR = 8'h00;
  localparam int OP_ADDI  = 8'h01;
  localparam int OP_ADDM  = 8'h02;
  localparam int OP_STORE = 8'h03;
  localparam int OP_BNZ   = 8'h04;
  localparam int OP_LINK  = 8'h05;

endpackage

// File: rtl/acc_decoder.sv
module acc_decoder
  import acc_core_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl         = '0;
    ctrl.acc_src = ASRC_ALU;
    ctrl.y_src   = YSRC_IMM;
    ctrl.alu_op  = ALU_PASS_X;
    case (opcode)
      OPC_W'(OP_CLEAR): begin
        ctrl.acc_we = 1'b1;
        ctrl.alu_op = ALU_ZERO;
      end
      OPC_W'(OP_ADDI): begin
        ctrl.acc_we = 1'b1;
        ctrl.alu_op = ALU_ADD;
      end
      OPC_W'(OP_ADDM): begin
        ctrl.acc_we = 1'b1;
        ctrl.y_src  = YSRC_MEM;
        ctrl.alu_op = ALU_ADD;
      end
      OPC_W'(OP_STORE): begin
        ctrl.mem_we = 1'b1;
      end
      OPC_W'(OP_BNZ): begin
        ctrl.br_nz = 1'b1;
      end
      OPC_W'(OP_LINK): begin
        ctrl.acc_we  = 1'b1;
        ctrl.acc_src = ASRC_LINK;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] res
);

  always_comb begin
    case (op)
      ALU_PASS_X: res = x;
      ALU_SUB:    res = x - y;
      ALU_PASS_Y: res = y;
      ALU_ADD:    res = x + y;
      default:    res = '0;
    endcase
  end

endmodule

// File: rtl/acc_pc_unit.sv
module acc_pc_unit #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            jump,
  input  logic            br_nz,
  input  logic            acc_nz,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] pc_link
);

  logic [PC_W-1:0] pc_q;
  logic            load_target;

  assign pc_link     = pc_q + PC_W'(2);
  assign load_target = jump | (br_nz & acc_nz);

  always_ff @(posedge clk) begin
    if (rst)              pc_q <= '0;
    else if (load_target) pc_q <= target;
    else                  pc_q <= pc_link;
  end

  assign pc = pc_q;

  // R2: sequential step by two with wrap
  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    !load_target |=> pc_q == PC_W'($past(pc_q) + PC_W'(2)));

  // R7: taken branch lands on the operand
  a_r7_branch_target: assert property (@(posedge clk) disable iff (rst)
    load_target |=> pc_q == $past(target));

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  output logic [DATA_W-1:0]  imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  output logic [DATA_W-1:0]  dmem_addr,
  output logic [DATA_W-1:0]  dmem_wdata,
  output logic               dmem_we,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic [DATA_W-1:0]  acc_value
);

  localparam int OPC_W = INSTR_W - DATA_W;

  logic [OPC_W-1:0]  opcode;
  logic [DATA_W-1:0] operand;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] acc_q, acc_d, alu_y, alu_res, pc, pc_link;

  assign opcode  = imem_rdata[INSTR_W-1:DATA_W];
  assign operand = imem_rdata[DATA_W-1:0];

  acc_decoder #(.OPC_W(OPC_W)) u_dec (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  assign alu_y = (ctrl.y_src == YSRC_MEM) ? dmem_rdata : operand;

  acc_alu #(.W(DATA_W)) u_alu (
    .op  (ctrl.alu_op),
    .x   (acc_q),
    .y   (alu_y),
    .res (alu_res)
  );

  acc_pc_unit #(.PC_W(DATA_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .jump    (ctrl.jump),
    .br_nz   (ctrl.br_nz),
    .acc_nz  (|acc_q),
    .target  (operand),
    .pc      (pc),
    .pc_link (pc_link)
  );

  assign acc_d = (ctrl.acc_src == ASRC_LINK) ? pc_link : alu_res;

  always_ff @(posedge clk) begin
    if (rst)              acc_q <= '0;
    else if (ctrl.acc_we) acc_q <= acc_d;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = operand;
  assign dmem_wdata = acc_q;
  assign dmem_we    = ctrl.mem_we;
  assign acc_value  = acc_q;

  // R1: reset clears architectural state
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (imem_addr == '0 && acc_value == '0));

  // R3: clear forces zero
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
    opcode == OPC_W'(OP_CLEAR) |=> acc_value == '0);

  // R6: store leaves the accumulator alone
  a_r6_store_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> acc_value == $past(acc_value));

  // R10: write strobe only for store
  a_r10_we_only_store: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> opcode == OPC_W'(OP_STORE));

  // R7: branch never alters the accumulator
  a_r7_branch_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    opcode == OPC_W'(OP_BNZ) |=> acc_value == $past(acc_value));

endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imem_addr, dmem_addr, dmem_wdata, dmem_rdata, acc_value;
  logic [15:0] imem_rdata;
  logic        dmem_we;

  logic [15:0] imem [128];
  logic [7:0]  dmem [256];

  int n_vec  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  acc_core u_dut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata),
    .acc_value  (acc_value)
  );

  assign imem_rdata = imem[imem_addr[7:1]];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string acc_req(input logic [7:0] op);
    case (op)
      8'h00:   return "R3";
      8'h01:   return "R4";
      8'h02:   return "R5";
      8'h03:   return "R6";
      8'h04:   return "R7";
      8'h05:   return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic put(input int byte_addr, input logic [7:0] op, input logic [7:0] arg);
    imem[byte_addr/2] = {op, arg};
  endtask

  // reference model state
  logic [7:0] m_pc, m_acc, m_op, m_arg;
  logic [7:0] m_mem [256];
  logic       m_prev_rst;

  initial begin
    for (int i = 0; i < 128; i++) imem[i] = 16'hFF00;
    for (int i = 0; i < 256; i++) begin dmem[i] = 8'h00; m_mem[i] = 8'h00; end
    put(0,   8'h00, 8'h00);  // clear
    put(2,   8'h01, 8'h05);  // A=5
    put(4,   8'h03, 8'h10);  // mem[10]=5
    put(6,   8'h01, 8'hFE);  // wrap to 3
    put(8,   8'h02, 8'h10);  // A=8
    put(10,  8'h03, 8'h11);
    put(12,  8'h05, 8'h00);  // A=14
    put(14,  8'h77, 8'h33);  // undefined: no-op
    put(16,  8'h00, 8'h00);
    put(18,  8'h04, 8'h40);  // not taken
    put(20,  8'h01, 8'hFD);
    put(22,  8'h04, 8'h30);  // taken
    put(24,  8'h01, 8'h01);  // skipped
    put(48,  8'h02, 8'h11);  // 253+8 wraps
    put(50,  8'h01, 8'hFB);  // 0
    put(52,  8'h04, 8'h00);  // not taken
    put(54,  8'h01, 8'h01);
    put(56,  8'h03, 8'hFF);
    put(58,  8'h04, 8'hFE);  // taken to 254
    put(254, 8'h05, 8'h00);  // link wraps to 0, PC wraps to 0
  end

  initial begin
    m_pc = '0; m_acc = '0; m_prev_rst = 1'b1;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      // compare outputs after the previous edge
      m_op  = imem[m_pc[7:1]][15:8];
      m_arg = imem[m_pc[7:1]][7:0];
      check(imem_addr == m_pc, m_prev_rst ? "R1" : (m_op == 8'h04 ? "R7" : "R2"),
            "fetch address", imem_addr, m_pc);
      check(acc_value == m_acc, m_prev_rst ? "R1" : acc_req(m_op),
            "accumulator", acc_value, m_acc);
      if (m_op == 8'h03) begin
        check(dmem_we == 1'b1, "R6", "write strobe", dmem_we, 1);
        check(dmem_addr == m_arg, "R6", "write address", dmem_addr, m_arg);
        check(dmem_wdata == m_acc, "R6", "write data", dmem_wdata, m_acc);
      end else begin
        check(dmem_we == 1'b0, "R10", "write strobe idle", dmem_we, 0);
      end
      if (m_op == 8'h02)
        check(dmem_addr == m_arg, "R5", "read address", dmem_addr, m_arg);
      // drive reset for the coming edge
      rst = (cyc < 2) || (cyc == 200) || (cyc == 201);
      // advance model
      if (rst) begin
        m_pc = '0; m_acc = '0;
      end else begin
        case (m_op)
          8'h00: begin m_acc = 0; m_pc = m_pc + 8'd2; end
          8'h01: begin m_acc = m_acc + m_arg; m_pc = m_pc + 8'd2; end
          8'h02: begin m_acc = m_acc + m_mem[m_arg]; m_pc = m_pc + 8'd2; end
          8'h03: begin m_mem[m_arg] = m_acc; m_pc = m_pc + 8'd2; end
          8'h04: m_pc = (m_acc != 0) ? m_arg : m_pc + 8'd2;
          8'h05: begin m_acc = m_pc + 8'd2; m_pc = m_pc + 8'd2; end
          default: m_pc = m_pc + 8'd2;
        endcase
      end
      m_prev_rst = rst;
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule